// File: doc/BRIEF.md
# Sprite and Sample DMA Bus Arbiter

This block sits between a small 8-bit CPU and the external bus. It takes the bus away from the processor for two kinds of transfer. The first is a sprite copy: a CPU write to the sprite trigger register names a source page, and the block moves all 256 bytes of that page, one byte at a time, into the fixed sprite-data port of the video chip. The second is an audio sample fetch: a single byte is read from a running sample address and handed to the audio channel.

The block stalls the CPU through a ready line. A low ready only takes hold when the CPU reaches a read cycle, so the CPU may finish its pending write cycles first. On every cycle the block picks exactly one of four address sources for the external bus. During a sprite copy it keeps each byte it reads and drives that byte back out on the following write cycle. A sample fetch outranks a sprite copy. When the sample channel is switched on, the first fetch is delayed and has a shortened stall.

Top module: `bus_dma_arbiter`

## Requirements
- R1: A CPU write to address 0x4014 while `phi1` is low drives `rdy` low in that same cycle.
- R2: While `rdy` is low and the CPU is still writing, each write reaches the bus unchanged with `addr_src` = 0. The copy starts only on the first cycle in which the CPU presents a read (`cpu_rd` high).
- R3: The write data of the trigger write becomes the high address byte of the copy. Reads use addresses {page, 0x00} through {page, 0xFF} in increasing order, exactly 256 of them.
- R4: Each sprite read cycle (`addr_src` = 2, `ext_we` low) is followed by a write cycle (`addr_src` = 3) to 0x2004 with `ext_we` high. The write drives the byte that was read.
- R5: Counted from the halt cycle to its last write, a copy keeps `rdy` low for 513 cycles. The count is 514 when the halt cycle falls on an odd cycle of the internal cycle parity. Both lengths occur depending on when the copy starts.
- R6: `addr_src` codes are 0 = CPU, 1 = sample fetch, 2 = sprite read, 3 = sprite-port write. `ext_addr` follows the selected source. Whenever `rdy` is high, the source is the CPU.
- R7: A write to 0x4015 with data bit 4 set keeps `rdy` high on that cycle and on the next two cycles. Then `rdy` is low for three cycles while the CPU reads, and the third of those cycles is the fetch (`addr_src` = 1).
- R8: While the channel is enabled and idle, a one-cycle `smp_req` pulse drives `rdy` low for the next four cycles, with the fetch on the fourth. After a write to 0x4015 with bit 4 clear, `smp_req` is ignored: `rdy` stays high and no fetch occurs.
- R9: An enabling write loads the sample address with 0xC000 + 64 × `smp_base`. The address increments after every fetch, and 0xFFFF is followed by 0x8000.
- R10: On the cycle after a fetch, `smp_valid` is high for one cycle and `smp_data` holds the byte that was read.
- R11: Writes to 0x4014 or 0x4015 made while `phi1` is high have no effect: `rdy` stays high and no transfer starts.
- R12: A sample request during a sprite copy is served within the copy. The copy then continues without losing or repeating any byte, and its length grows by one cycle per fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi1 | input | 1 | First clock phase; register writes are decoded only while low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU is on a read cycle |
| mem_rdata | input | 8 | Read data from the external bus |
| smp_base | input | 8 | Programmed sample start value |
| smp_req | input | 1 | Audio channel asks for the next sample byte |
| rdy | output | 1 | CPU ready; low stalls the CPU on its next read |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_we | output | 1 | External bus write strobe |
| addr_src | output | 2 | Selected address source code |
| smp_data | output | 8 | Last fetched sample byte |
| smp_valid | output | 1 | One-cycle pulse when `smp_data` is new |

## Verification
The bench builds the block with its default parameters: an 8-bit page index, a two-cycle arming delay, and stalls of three and four cycles. These values keep a full 256-byte copy to about 520 cycles, so several whole copies fit in one run and every byte of each is compared. The bench sweeps all 256 sample start values and walks the sample address across its wrap point. It changes the idle gap between copies so that both halt-cycle parities, and therefore both copy lengths, are reached.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    SRC_CPU    = 2'd0,
    SRC_SMP    = 2'd1,
    SRC_SPR_RD = 2'd2,
    SRC_SPR_WR = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    SP_IDLE,
    SP_WAIT,
    SP_ALIGN,
    SP_RD,
    SP_WR
  } spr_st_e;

  typedef enum logic [1:0] {
    SM_IDLE,
    SM_ARM,
    SM_STALL
  } smp_st_e;

endpackage

// File: rtl/spr_dma_ctrl.sv
// Sprite page copier: waits for the CPU to halt, optionally spends one
// alignment cycle, then alternates read and port-write cycles.
module spr_dma_ctrl
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [PAGE_W-1:0] trig_data,
  input  logic              cpu_rd,
  input  logic              hold,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              halted,
  output logic              rd_phase,
  output logic              wr_phase,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int IDX_W = ADDR_W - PAGE_W;
  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  spr_st_e           st_q, st_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] lat_q, lat_d;
  logic              odd_q;

  always_comb begin
    st_d   = st_q;
    page_d = page_q;
    idx_d  = idx_q;
    lat_d  = lat_q;
    case (st_q)
      SP_IDLE: begin
        if (trig) begin
          st_d   = SP_WAIT;
          page_d = trig_data;
          idx_d  = '0;
        end
      end
      SP_WAIT: begin
        if (cpu_rd && !hold) st_d = odd_q ? SP_ALIGN : SP_RD;
      end
      SP_ALIGN: begin
        if (!hold) st_d = SP_RD;
      end
      SP_RD: begin
        if (!hold) begin
          lat_d = rd_data;
          st_d  = SP_WR;
        end
      end
      SP_WR: begin
        if (!hold) begin
          idx_d = idx_q + 1'b1;
          st_d  = (idx_q == IDX_LAST) ? SP_IDLE : SP_RD;
        end
      end
      default: st_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SP_IDLE;
      page_q <= '0;
      idx_q  <= '0;
      lat_q  <= '0;
      odd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      page_q <= page_d;
      idx_q  <= idx_d;
      lat_q  <= lat_d;
      odd_q  <= ~odd_q;
    end
  end

  assign busy     = (st_q != SP_IDLE);
  assign halted   = (st_q == SP_ALIGN) || (st_q == SP_RD) || (st_q == SP_WR);
  assign rd_phase = (st_q == SP_RD) && !hold;
  assign wr_phase = (st_q == SP_WR) && !hold;
  assign rd_addr  = {page_q, idx_q};
  assign wr_data  = lat_q;

endmodule

// File: rtl/smp_dma_ctrl.sv
// Sample fetcher: delayed first fetch after enable, fixed dead-cycle
// stall per fetch, wrapping address counter.
module smp_dma_ctrl
  import dma_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          BASE_W      = 8,
  parameter int          BASE_SHIFT  = 6,
  parameter logic [15:0] BASE_ADDR   = 16'hC000,
  parameter logic [15:0] WRAP_ADDR   = 16'h8000,
  parameter int          ARM_DELAY   = 2,
  parameter int          STALL_ARMED = 3,
  parameter int          STALL_REQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              en_bit,
  input  logic [BASE_W-1:0] base,
  input  logic              req,
  input  logic              cpu_off,
  input  logic [DATA_W-1:0] rd_data,
  output logic              stall,
  output logic              fetch,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              valid
);

  localparam int MAX_A = (ARM_DELAY > STALL_ARMED) ? ARM_DELAY : STALL_ARMED;
  localparam int MAX_C = (MAX_A > STALL_REQ) ? MAX_A : STALL_REQ;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int PAD_W = ADDR_W - BASE_W - BASE_SHIFT;

  smp_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              halt_q, halt_d;
  logic              act_q, act_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              val_q, val_d;
  logic [ADDR_W-1:0] base_off;
  logic              counted;

  assign base_off = {{PAD_W{1'b0}}, base, {BASE_SHIFT{1'b0}}};
  assign counted  = halt_q || cpu_off;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    halt_d = halt_q;
    act_d  = act_q;
    addr_d = addr_q;
    data_d = data_q;
    val_d  = 1'b0;
    fetch  = 1'b0;
    if (en_wr) begin
      act_d = en_bit;
      if (en_bit) begin
        addr_d = BASE_ADDR + base_off;
        st_d   = SM_ARM;
        cnt_d  = CNT_W'(ARM_DELAY);
      end else begin
        st_d = SM_IDLE;
      end
    end else begin
      case (st_q)
        SM_IDLE: begin
          if (req && act_q) begin
            st_d   = SM_STALL;
            cnt_d  = CNT_W'(STALL_REQ);
            halt_d = 1'b0;
          end
        end
        SM_ARM: begin
          if (cnt_q <= CNT_W'(1)) begin
            st_d   = SM_STALL;
            cnt_d  = CNT_W'(STALL_ARMED);
            halt_d = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        SM_STALL: begin
          if (counted) begin
            halt_d = 1'b1;
            if (cnt_q <= CNT_W'(1)) begin
              fetch  = 1'b1;
              data_d = rd_data;
              val_d  = 1'b1;
              addr_d = (addr_q == {ADDR_W{1'b1}}) ? WRAP_ADDR : addr_q + 1'b1;
              st_d   = SM_IDLE;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: st_d = SM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SM_IDLE;
      cnt_q  <= '0;
      halt_q <= 1'b0;
      act_q  <= 1'b0;
      addr_q <= BASE_ADDR;
      data_q <= '0;
      val_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
      act_q  <= act_d;
      addr_q <= addr_d;
      data_q <= data_d;
      val_q  <= val_d;
    end
  end

  assign stall = (st_q == SM_STALL);
  assign addr  = addr_q;
  assign data  = data_q;
  assign valid = val_q;

endmodule

// File: rtl/bus_src_mux.sv
// Four-way external bus source select.
module bus_src_mux
  import dma_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] PORT_ADDR = 16'h2004
) (
  input  src_e              sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [ADDR_W-1:0] spr_addr,
  input  logic [DATA_W-1:0] spr_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we
);

  always_comb begin
    bus_addr  = cpu_addr;
    bus_wdata = cpu_wdata;
    bus_we    = cpu_we;
    case (sel)
      SRC_SMP: begin
        bus_addr = smp_addr;
        bus_we   = 1'b0;
      end
      SRC_SPR_RD: begin
        bus_addr = spr_addr;
        bus_we   = 1'b0;
      end
      SRC_SPR_WR: begin
        bus_addr  = PORT_ADDR;
        bus_wdata = spr_wdata;
        bus_we    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bus_dma_arbiter.sv
module bus_dma_arbiter
  import dma_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          PAGE_W      = 8,
  parameter int          BASE_W      = 8,
  parameter int          BASE_SHIFT  = 6,
  parameter logic [15:0] TRIG_ADDR   = 16'h4014,
  parameter logic [15:0] SND_ADDR    = 16'h4015,
  parameter logic [15:0] PORT_ADDR   = 16'h2004,
  parameter logic [15:0] SMP_BASE    = 16'hC000,
  parameter logic [15:0] SMP_WRAP    = 16'h8000,
  parameter int          SND_EN_BIT  = 4,
  parameter int          ARM_DELAY   = 2,
  parameter int          STALL_ARMED = 3,
  parameter int          STALL_REQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi1,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [BASE_W-1:0] smp_base,
  input  logic              smp_req,
  output logic              rdy,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_we,
  output logic [1:0]        addr_src,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_valid
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // write decode, qualified by the low first phase
  logic wr_ok, trig_hit, snd_hit;
  assign wr_ok    = cpu_we && !phi1;
  assign trig_hit = wr_ok && (cpu_addr == TRIG_ADDR);
  assign snd_hit  = wr_ok && (cpu_addr == SND_ADDR);

  logic              spr_busy, spr_halted, spr_rd, spr_wr;
  logic [ADDR_W-1:0] spr_addr;
  logic [DATA_W-1:0] spr_wdata;
  logic              smp_stall, smp_fetch;
  logic [ADDR_W-1:0] smp_addr;
  src_e              sel;

  spr_dma_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
  ) u_spr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .trig     (trig_hit),
    .trig_data(cpu_wdata[PAGE_W-1:0]),
    .cpu_rd   (cpu_rd),
    .hold     (smp_fetch),
    .rd_data  (mem_rdata),
    .busy     (spr_busy),
    .halted   (spr_halted),
    .rd_phase (spr_rd),
    .wr_phase (spr_wr),
    .rd_addr  (spr_addr),
    .wr_data  (spr_wdata)
  );

  smp_dma_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_W(BASE_W), .BASE_SHIFT(BASE_SHIFT),
    .BASE_ADDR(SMP_BASE), .WRAP_ADDR(SMP_WRAP), .ARM_DELAY(ARM_DELAY),
    .STALL_ARMED(STALL_ARMED), .STALL_REQ(STALL_REQ)
  ) u_smp (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .en_wr  (snd_hit),
    .en_bit (cpu_wdata[SND_EN_BIT]),
    .base   (smp_base),
    .req    (smp_req),
    .cpu_off(cpu_rd || spr_halted),
    .rd_data(mem_rdata),
    .stall  (smp_stall),
    .fetch  (smp_fetch),
    .addr   (smp_addr),
    .data   (smp_data),
    .valid  (smp_valid)
  );

  always_comb begin
    if (smp_fetch)   sel = SRC_SMP;
    else if (spr_rd) sel = SRC_SPR_RD;
    else if (spr_wr) sel = SRC_SPR_WR;
    else             sel = SRC_CPU;
  end

  bus_src_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
  ) u_mux (
    .sel      (sel),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_we   (cpu_we),
    .smp_addr (smp_addr),
    .spr_addr (spr_addr),
    .spr_wdata(spr_wdata),
    .bus_addr (ext_addr),
    .bus_wdata(ext_wdata),
    .bus_we   (ext_we)
  );

  assign addr_src = sel;
  assign rdy      = !(spr_busy || trig_hit || smp_stall);

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phi1,
  input logic [15:0] cpu_addr,
  input logic        cpu_we,
  input logic        rdy,
  input logic [15:0] ext_addr,
  input logic        ext_we,
  input logic [1:0]  addr_src,
  input logic        smp_valid
);

  // R1: trigger write stalls in the same cycle
  p_trig_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !phi1 && cpu_addr == 16'h4014) |-> !rdy);

  // R4: sprite-port writes go to the fixed port and are writes
  p_port_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_src == 2'd3) |-> (ext_addr == 16'h2004 && ext_we));

  // R4: a port write is preceded by a read or an interposed sample fetch
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_src == 2'd3) |-> ($past(addr_src) == 2'd2 || $past(addr_src) == 2'd1));

  // R6: ready high means the CPU owns the bus
  p_rdy_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (addr_src == 2'd0 && ext_addr == cpu_addr));

  // R9: sample fetches read the upper half of memory
  p_smp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_src == 2'd1) |-> (ext_addr[15] && !ext_we));

  // R10: a fetch is reported on the next cycle
  p_valid_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_src == 2'd1) |=> smp_valid);

endmodule

bind bus_dma_arbiter dma_arb_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phi1     (phi1),
  .cpu_addr (cpu_addr),
  .cpu_we   (cpu_we),
  .rdy      (rdy),
  .ext_addr (ext_addr),
  .ext_we   (ext_we),
  .addr_src (addr_src),
  .smp_valid(smp_valid)
);

// File: tb/tb_bus_dma_arbiter.sv
module tb_bus_dma_arbiter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        phi1;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we;
  logic        cpu_rd;
  logic [7:0]  mem_rdata;
  logic [7:0]  smp_base;
  logic        smp_req;
  logic        rdy;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_we;
  logic [1:0]  addr_src;
  logic [7:0]  smp_data;
  logic        smp_valid;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc_n  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = memf(ext_addr);

  bus_dma_arbiter dut (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rd(cpu_rd),
    .mem_rdata(mem_rdata), .smp_base(smp_base), .smp_req(smp_req),
    .rdy(rdy), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we),
    .addr_src(addr_src), .smp_data(smp_data), .smp_valid(smp_valid)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    phi1      = 1'b0;
    cpu_we    = 1'b0;
    cpu_rd    = 1'b1;
    cpu_addr  = 16'h0090;
    cpu_wdata = 8'h00;
    smp_req   = 1'b0;
  endtask

  task automatic run_sprite(input logic [7:0] page, input int extra,
                            input int req_a, input int req_b,
                            output int len, output int nsmp);
    int rd_i = 0;
    int wr_i = 0;
    int bad  = 0;
    cpu_addr = 16'h4014; cpu_wdata = page; cpu_we = 1'b1; cpu_rd = 1'b0;
    #1 chk(rdy == 1'b0, "R1 rdy on trigger", rdy, 0);
    step();
    for (int k = 0; k < extra; k++) begin
      cpu_addr = 16'h0300 + 16'(k); cpu_wdata = 8'(k + 1);
      #1 chk(addr_src == 2'd0 && ext_we && ext_addr == cpu_addr && !rdy,
             "R2 write passes while stalled", {addr_src, ext_addr}, {2'd0, cpu_addr});
      step();
    end
    cpu_we = 1'b0; cpu_rd = 1'b1; cpu_addr = 16'h0090;
    len = 0; nsmp = 0;
    for (int g = 0; g < 2000; g++) begin
      smp_req = (len == req_a) || (len == req_b);
      #1;
      if (rdy) break;
      case (addr_src)
        2'd1: nsmp++;
        2'd2: begin
          if (ext_addr != {page, 8'(rd_i)} || ext_we) bad++;
          rd_i++;
        end
        2'd3: begin
          if (ext_addr != 16'h2004 || !ext_we || ext_wdata != memf({page, 8'(wr_i)})) bad++;
          wr_i++;
        end
        default: ;
      endcase
      len++;
      step();
    end
    smp_req = 1'b0;
    chk(rd_i == 256, "R3 read count", rd_i, 256);
    chk(wr_i == 256, "R4 write count", wr_i, 256);
    chk(bad == 0, "R4 R3 pair address/data mismatches", bad, 0);
  endtask

  task automatic en_fetch(input logic [7:0] b);
    logic [15:0] a;
    a = 16'hC000 + {2'b00, b, 6'b000000};
    cpu_addr = 16'h4015; cpu_wdata = 8'h10; smp_base = b; cpu_we = 1'b1; cpu_rd = 1'b0;
    #1 chk(rdy, "R7 rdy high on enable write", rdy, 1);
    step();
    cpu_we = 1'b0; cpu_rd = 1'b1; cpu_addr = 16'h0090;
    for (int i = 1; i <= 5; i++) begin
      #1;
      if (i <= 2) chk(rdy == 1'b1, "R7 delay before stall", rdy, 1);
      else        chk(rdy == 1'b0, "R7 dead cycle", rdy, 0);
      if (i < 5) chk(addr_src == 2'd0, "R7 no early fetch", addr_src, 0);
      else       chk(addr_src == 2'd1 && ext_addr == a, "R9 start address", ext_addr, a);
      step();
    end
    #1 chk(rdy && smp_valid && smp_data == memf(a), "R10 sample output",
           {smp_valid, smp_data}, {1'b1, memf(a)});
    step();
  endtask

  task automatic req_fetch(input logic [15:0] a);
    smp_req = 1'b1;
    #1 chk(rdy, "R8 rdy high at request", rdy, 1);
    step();
    smp_req = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      #1 chk(!rdy, "R8 dead cycle", rdy, 0);
      if (i < 4) chk(addr_src == 2'd0, "R8 no early fetch", addr_src, 0);
      else       chk(addr_src == 2'd1 && ext_addr == a, "R9 fetch address", ext_addr, a);
      step();
    end
    #1 chk(rdy && smp_valid && smp_data == memf(a), "R10 sample after request",
           {smp_valid, smp_data}, {1'b1, memf(a)});
    step();
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int len, nsmp;
    bit seen0, seen1;
    logic [7:0]  pages [5] = '{8'h00, 8'h03, 8'h7F, 8'hFF, 8'h5A};
    int          extras[5] = '{0, 0, 1, 0, 0};
    int          gaps  [5] = '{0, 0, 0, 1, 0};
    rst_n = 1'b0;
    smp_base = 8'h00;
    idle_in();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R6)
    #1 chk(rdy && addr_src == 2'd0 && ext_addr == cpu_addr && !smp_valid,
           "R6 reset state", {rdy, addr_src}, {1'b1, 2'd0});
    step();

    // R11: writes during high first phase are ignored
    phi1 = 1'b1; cpu_we = 1'b1; cpu_rd = 1'b0; cpu_addr = 16'h4014; cpu_wdata = 8'h12;
    #1 chk(rdy, "R11 trigger ignored in phi1", rdy, 1);
    step();
    cpu_addr = 16'h4015; cpu_wdata = 8'h10;
    #1 chk(rdy, "R11 enable ignored in phi1", rdy, 1);
    step();
    idle_in();
    for (int i = 0; i < 8; i++) begin
      #1 chk(rdy && addr_src == 2'd0 && !smp_valid, "R11 R6 no transfer",
             {rdy, addr_src}, {1'b1, 2'd0});
      step();
    end

    // sprite sweep, varying start parity (R1..R5)
    seen0 = 1'b0; seen1 = 1'b0;
    for (int r = 0; r < 5; r++) begin
      for (int g = 0; g < gaps[r]; g++) step();
      run_sprite(pages[r], extras[r], -1, -1, len, nsmp);
      chk(len == 513 || len == 514, "R5 copy length", len, 513);
      if (r > 0 && len == 513) seen0 = 1'b1;
      if (r > 0 && len == 514) seen1 = 1'b1;
      chk(nsmp == 0, "R6 no fetch without request", nsmp, 0);
    end
    chk(seen0 && seen1, "R5 both lengths reached", {seen0, seen1}, 2'b11);

    // sample start address sweep (R7, R9, R10)
    for (int b = 0; b < 256; b++) en_fetch(8'(b));

    // address run-up to wrap (R8, R9)
    en_fetch(8'hFF);
    for (int k = 1; k <= 64; k++) begin
      logic [16:0] a;
      a = 17'h0FFC0 + 17'(k);
      req_fetch(a[16] ? (16'h8000 + a[15:0]) : a[15:0]);
    end

    // R12: sample priority inside a sprite copy
    en_fetch(8'h20);
    run_sprite(8'h44, 0, 100, 301, len, nsmp);
    chk(nsmp == 2, "R12 fetches served in copy", nsmp, 2);
    chk(len - 2 == 513 || len - 2 == 514, "R12 copy length grows per fetch", len, 515);

    // R8: requests ignored after disable
    cpu_addr = 16'h4015; cpu_wdata = 8'h00; cpu_we = 1'b1; cpu_rd = 1'b0;
    #1 chk(rdy, "R8 disable write", rdy, 1);
    step();
    idle_in();
    smp_req = 1'b1;
    step();
    smp_req = 1'b0;
    for (int i = 0; i < 6; i++) begin
      #1 chk(rdy && addr_src == 2'd0 && !smp_valid, "R8 request ignored when disabled",
             {rdy, addr_src, smp_valid}, {1'b1, 2'd0, 1'b0});
      step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule